// File: doc/BRIEF.md
# Triangular Dither PWM Sequencer

This block drives a single PWM pin whose duty cycle is stepped through a small table of compare values, one step per carrier period. An external RC network smooths the pin into a slow triangular ramp. That ramp is summed onto an analog input ahead of a converter, so the input is swept evenly between two adjacent codes across one oversampling window. The carrier period is set by an auto-reload value and is made equal to one converter sample period. The block also gives a one-cycle sample strobe at the start of every carrier period inside a window, which paces the converter.

A separate sampling timer supplies a trigger pulse. Each trigger zeroes the carrier counter and starts a window of `osr_len` carrier periods. Period k of the window uses table entry k. When the last period ends, the compare value falls back to a programmable idle value and the pin keeps running at that duty until the next trigger. The table is written one entry at a time through a simple write port. A compare value of zero holds the pin low. Any value above the reload value holds it high. The pin's duty cycle can therefore reach both 0% and 100%.

Top module: `tri_dither_pwm`

## Requirements
- R1: While and right after reset, `pwm_out` is low, `sample_stb` is low and `window_active` is low.
- R2: The carrier counter counts 0 to `reload` and then wraps, so one carrier period lasts `reload`+1 cycles. An accepted trigger zeroes the counter, and the first cycle after the trigger edge is counter value 0.
- R3: `pwm_out` is high exactly while the counter is below the current compare value. The compare value is `CNT_W`+1 bits wide. A value of 0 keeps the pin low for the whole period, and any value above `reload` keeps it high for the whole period. The compare value never changes in the middle of a period.
- R4: After an accepted trigger, carrier period k (counting from 0) of the window uses table entry k. A window runs for exactly L periods, where L is the effective length.
- R5: `sample_stb` is high for one cycle at counter value 0 of each period in a window. This gives exactly L strobes per window, and there are none outside a window.
- R6: `window_active` is high for exactly L×(`reload`+1) cycles, starting with the first cycle after the trigger edge.
- R7: After the last window period, the compare value is `idle_cmp`. While no window is running, a change to `idle_cmp` takes effect only at the next counter wrap.
- R8: A trigger that arrives during a window restarts the window from entry 0 with the counter zeroed.
- R9: A trigger with `osr_len` = 0 is ignored. No window starts, no strobe is issued, and the counter and `pwm_out` continue undisturbed.
- R10: An `osr_len` above `DEPTH` is treated as `DEPTH`. The length is captured at the trigger.
- R11: A table write with `tbl_wr_en` high stores `tbl_wr_data` at `tbl_wr_addr` on the clock edge. A write made during a window to an entry that has not yet been used is applied when that entry's period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Sampling-period trigger, one cycle |
| reload | input | CNT_W | Carrier counter top value |
| osr_len | input | $clog2(DEPTH+1) | Window length in carrier periods |
| idle_cmp | input | CNT_W+1 | Compare value used outside a window |
| tbl_wr_en | input | 1 | Table write enable |
| tbl_wr_addr | input | $clog2(DEPTH) | Table entry to write |
| tbl_wr_data | input | CNT_W+1 | Compare value to store |
| pwm_out | output | 1 | PWM pin |
| sample_stb | output | 1 | Strobe at the start of each window period |
| window_active | output | 1 | High during a window |

## Verification
The hardest cases to reach are the events that land at a particular phase of the carrier. These are a retrigger partway through a period, a table write to an entry that a running window has not yet reached, and an idle-value change in the middle of an idle period. None of them can be seen through a status port. The bench keeps the carrier phase known by always counting cycles from its own trigger edge. It then drives the retrigger, the late table write and the idle change at chosen cycle offsets inside that count. Finally, it compares the pin, strobe and window flag on every cycle against a model of the stepped period sequence.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic start;
        logic advance;
        logic finish;
        logic idle_wrap;
    } seq_evt_t;

    function automatic int clamp_len(input int req, input int depth);
        return (req > depth) ? depth : req;
    endfunction

endpackage

// File: rtl/tdp_carrier.sv
module tdp_carrier #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    assign wrap = (cnt >= reload);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart || wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/tdp_table.sv
module tdp_table #(
    parameter int DW    = 9,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [DEPTH];
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_dec
        assign hit[g] = wr_en && (wr_addr == AW'(g));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hit[i]) mem[i] <= wr_data;
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tdp_seq.sv
module tdp_seq
    import tdp_pkg::*;
#(
    parameter int CMP_W = 9,
    parameter int DEPTH = 16,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             wrap,
    input  logic [LEN_W-1:0] osr_len,
    input  logic [CMP_W-1:0] idle_cmp,
    input  logic [CMP_W-1:0] rd_data,
    output logic [IDX_W-1:0] rd_addr,
    output logic [CMP_W-1:0] cmp,
    output logic             active,
    output logic             stb,
    output logic             start,
    output logic [LEN_W-1:0] idx
);

    seq_state_e       st;
    seq_evt_t         evt;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_eff;

    assign len_eff = LEN_W'(clamp_len(int'(osr_len), DEPTH));
    assign active  = (st == SEQ_RUN);

    always_comb begin
        evt.start     = trig && (osr_len != '0);
        evt.advance   = !evt.start && wrap && active && (idx != len_q);
        evt.finish    = !evt.start && wrap && active && (idx == len_q);
        evt.idle_wrap = !evt.start && wrap && !active;
    end

    assign start   = evt.start;
    assign rd_addr = evt.start ? '0 : idx[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SEQ_IDLE;
            idx   <= '0;
            len_q <= '0;
            cmp   <= '0;
            stb   <= 1'b0;
        end else begin
            stb <= 1'b0;
            if (evt.start) begin
                st    <= SEQ_RUN;
                len_q <= len_eff;
                cmp   <= rd_data;
                idx   <= LEN_W'(1);
                stb   <= 1'b1;
            end else if (evt.advance) begin
                cmp <= rd_data;
                idx <= idx + LEN_W'(1);
                stb <= 1'b1;
            end else if (evt.finish) begin
                st  <= SEQ_IDLE;
                cmp <= idle_cmp;
            end else if (evt.idle_wrap) begin
                cmp <= idle_cmp;
            end
        end
    end

endmodule

// File: rtl/tri_dither_pwm.sv
module tri_dither_pwm #(
    parameter int CNT_W = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       trig,
    input  logic [CNT_W-1:0]           reload,
    input  logic [$clog2(DEPTH+1)-1:0] osr_len,
    input  logic [CNT_W:0]             idle_cmp,
    input  logic                       tbl_wr_en,
    input  logic [$clog2(DEPTH)-1:0]   tbl_wr_addr,
    input  logic [CNT_W:0]             tbl_wr_data,
    output logic                       pwm_out,
    output logic                       sample_stb,
    output logic                       window_active
);

    localparam int CMP_W = CNT_W + 1;
    localparam int LEN_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    logic             start;
    logic [CMP_W-1:0] cmp_q;
    logic [CMP_W-1:0] tbl_rd_data;
    logic [IDX_W-1:0] tbl_rd_addr;
    logic             active;
    logic             stb;
    logic [LEN_W-1:0] idx_q;

    tdp_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .reload  (reload),
        .cnt     (cnt_q),
        .wrap    (wrap)
    );

    tdp_table #(.DW(CMP_W), .DEPTH(DEPTH)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_wr_en),
        .wr_addr (tbl_wr_addr),
        .wr_data (tbl_wr_data),
        .rd_addr (tbl_rd_addr),
        .rd_data (tbl_rd_data)
    );

    tdp_seq #(.CMP_W(CMP_W), .DEPTH(DEPTH)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .trig     (trig),
        .wrap     (wrap),
        .osr_len  (osr_len),
        .idle_cmp (idle_cmp),
        .rd_data  (tbl_rd_data),
        .rd_addr  (tbl_rd_addr),
        .cmp      (cmp_q),
        .active   (active),
        .stb      (stb),
        .start    (start),
        .idx      (idx_q)
    );

    assign pwm_out       = ({1'b0, cnt_q} < cmp_q);
    assign sample_stb    = stb;
    assign window_active = active;

endmodule

// File: rtl/tdp_chk.sv
module tdp_chk #(
    parameter int CNT_W = 8,
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       trig,
    input logic [$clog2(DEPTH+1)-1:0] osr_len,
    input logic [CNT_W:0]             idle_cmp,
    input logic [CNT_W-1:0]           cnt,
    input logic                       wrap,
    input logic                       start,
    input logic [CNT_W:0]             cmp,
    input logic                       active,
    input logic                       stb,
    input logic [$clog2(DEPTH+1)-1:0] idx
);

    p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0));

    p_cmp_held_r3: assert property (@(posedge clk) disable iff (rst)
        (!wrap && !start) |=> $stable(cmp));

    p_stb_in_window_r5: assert property (@(posedge clk) disable iff (rst)
        stb |-> (active && cnt == '0));

    p_idle_after_window_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> (cmp == $past(idle_cmp)));

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (trig && osr_len != '0) |=> (cnt == '0 && stb && active));

    p_zero_len_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (trig && osr_len == '0 && !active) |=> !active);

    p_idx_bound_r10: assert property (@(posedge clk) disable iff (rst)
        active |-> (idx <= ($clog2(DEPTH+1))'(DEPTH)));

endmodule

bind tri_dither_pwm tdp_chk #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .trig     (trig),
    .osr_len  (osr_len),
    .idle_cmp (idle_cmp),
    .cnt      (cnt_q),
    .wrap     (wrap),
    .start    (start),
    .cmp      (cmp_q),
    .active   (active),
    .stb      (stb),
    .idx      (idx_q)
);

// File: tb/sim_tri_dither_pwm.sv
module sim_tri_dither_pwm;

    localparam int CNT_W = 8;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       trig = 1'b0;
    logic [7:0] reload = 8'd7;
    logic [4:0] osr_len = 5'd0;
    logic [8:0] idle_cmp = 9'd0;
    logic       tbl_wr_en = 1'b0;
    logic [3:0] tbl_wr_addr = '0;
    logic [8:0] tbl_wr_data = '0;
    logic       pwm_out, sample_stb, window_active;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int exp_tbl [DEPTH];

    always #4 clk = ~clk;

    tri_dither_pwm #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .trig(trig), .reload(reload),
        .osr_len(osr_len), .idle_cmp(idle_cmp),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr),
        .tbl_wr_data(tbl_wr_data), .pwm_out(pwm_out),
        .sample_stb(sample_stb), .window_active(window_active)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic put_entry(input int i, input int v);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_addr = 4'(i); tbl_wr_data = 9'(v);
        exp_tbl[i] = v;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic load_triangle(input int len, input int step);
        for (int i = 0; i < len; i++)
            put_entry(i, (i <= len / 2) ? i * step : (len - i) * step);
    endtask

    // Pulses trig; returns at the negedge just after the trigger edge (j = 0).
    task automatic fire();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    // Per-cycle model of a window; encodes {pwm, stb, active}.
    task automatic follow_window(input string req, input int len, input int rl,
                                 input int idle, input int ncyc,
                                 input int wr_at, input int wr_i, input int wr_v);
        for (int j = 0; j < ncyc; j++) begin
            int p = j / (rl + 1);
            int c = j % (rl + 1);
            int cv, e;
            if (j == wr_at) begin
                tbl_wr_en = 1'b1; tbl_wr_addr = 4'(wr_i); tbl_wr_data = 9'(wr_v);
            end else begin
                tbl_wr_en = 1'b0;
            end
            if (j == wr_at + 1) exp_tbl[wr_i] = wr_v;
            if (p < len) begin
                cv = exp_tbl[p];
                e = ((c < cv) ? 4 : 0) + ((c == 0) ? 2 : 0) + 1;
            end else begin
                cv = idle;
                e = (c < cv) ? 4 : 0;
            end
            check(req, {29'd0, pwm_out, sample_stb, window_active}, e);
            @(negedge clk);
        end
        tbl_wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 pwm", int'(pwm_out), 0);
        check("R1 stb", int'(sample_stb), 0);
        check("R1 active", int'(window_active), 0);
    endtask

    task automatic t_basic();
        reload = 8'd7; idle_cmp = 9'd3; osr_len = 5'd8;
        load_triangle(8, 2);
        fire();
        follow_window("R2 R3 R4 R5 R6 R7 R11 triangle", 8, 7, 3, 10 * 8, -5, 0, 0);
    endtask

    task automatic t_full_reload();
        reload = 8'd55; idle_cmp = 9'd0; osr_len = 5'd16;
        load_triangle(16, 7);
        fire();
        follow_window("R2 R3 R4 reload 55", 16, 55, 0, 17 * 56, -5, 0, 0);
    endtask

    task automatic t_retrigger();
        reload = 8'd5; idle_cmp = 9'd1; osr_len = 5'd4;
        load_triangle(4, 3);
        fire();
        follow_window("R8 before retrigger", 4, 5, 1, 8, -5, 0, 0);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        follow_window("R8 after retrigger", 4, 5, 1, 6 * 6, -5, 0, 0);
    endtask

    task automatic t_idle_change();
        int hi;
        reload = 8'd7; idle_cmp = 9'd2; osr_len = 5'd1;
        put_entry(0, 5);
        fire();
        follow_window("R7 short window", 1, 7, 2, 9, -5, 0, 0);
        idle_cmp = 9'd8;
        for (int c = 1; c < 8; c++) begin
            check("R7 old idle kept mid-period", int'(pwm_out), (c < 2) ? 1 : 0);
            @(negedge clk);
        end
        hi = 0;
        for (int c = 0; c < 8; c++) begin
            hi += int'(pwm_out);
            @(negedge clk);
        end
        check("R7 new idle after wrap", hi, 8);
    endtask

    task automatic t_zero_len();
        int hi, st, ac;
        reload = 8'd7; idle_cmp = 9'd5; osr_len = 5'd0;
        repeat (20) @(negedge clk);
        fire();
        hi = 0; st = 0; ac = 0;
        for (int c = 0; c < 24; c++) begin
            st += int'(sample_stb);
            ac += int'(window_active);
            if (c >= 16) hi += int'(pwm_out);
            @(negedge clk);
        end
        check("R9 no strobe", st, 0);
        check("R9 no window", ac, 0);
        check("R9 idle duty undisturbed", hi, 5);
    endtask

    task automatic t_clamp();
        reload = 8'd3; idle_cmp = 9'd0; osr_len = 5'd31;
        for (int i = 0; i < DEPTH; i++) put_entry(i, i % 5);
        fire();
        follow_window("R10 R11 clamp and late write", 16, 3, 0, 18 * 4, 2, 9, 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_tbl[i] = 0;
        t_reset();
        t_basic();
        t_full_reload();
        t_retrigger();
        t_idle_change();
        t_zero_len();
        t_clamp();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule